// File: doc/BRIEF.md
# Core Idle Power-State Sequencer

This block runs the idle power states of one processor core, from the active state C0 down to C6. Firmware asks for a target depth. The sequencer then walks the core down one depth per clock and drives the control lines that each depth adds on top of the shallower ones:

- a pipeline halt;
- a gate for the core clock and the I/O buffers;
- a gate for the bus clock and the PLL;
- snoop disable, with either cache invalidation or blocking of memory transactions;
- a voltage-level select;
- a cache-shrink enable.

A wake event starts a latency countdown whose length depends on the depth being left. When the countdown ends the block is back in C0 and it pulses `ready`.

While the core sits in C4, a down-counter of L2 ways models the cache shrinking. It loses one way every `SHRINK_DIV` cycles. C5 can only be reached once that counter is empty, and C6 lies one step beyond C5. Waking from C6 also raises a context-lost flag.

A small resolver takes the core's own depth and the depths reported by its peer cores, and gives the package depth as the shallowest of them.

Top module: `idle_pwr_seq`

## Requirements
- R1: After reset, `cur_state` is 0 (C0), every control output and `vsel` are 0, `l2_ways` equals `L2_WAYS`, `ready`, `ctx_lost` and `waking` are 0.
- R2: Depths are coded as 3-bit binary, C0=0 through C6=6. A request with `req_state` from 1 to 6 is accepted when all of the following hold at the same edge: `cur_state` is 0, no wake is in progress, `ready` is low and `wake` is low. After acceptance, `cur_state` becomes 1 at that edge and then deepens by one per edge until it reaches the target. Requests for 0 or 7, or requests made outside C0, are ignored.
- R3: `halt` is high at depth 1 and deeper. `clk_gate` is high at depth 2 and deeper. `pll_gate` and `snoop_off` are high at depth 3 and deeper. `vsel` is 0 for C0 to C3, 1 for C4 and C5, and 2 for C6.
- R4: At depth 3 and deeper, `multi_proc`=1 gives `cache_inval`=1 and `mem_block`=0, while `multi_proc`=0 gives `mem_block`=1 and `cache_inval`=0. Below depth 3 both are 0.
- R5: In C4 with no wake pending or in progress, `shrink_en` is high. `l2_ways` then drops by one every `SHRINK_DIV` edges, the first drop coming `SHRINK_DIV` edges after C4 is entered, and it stops at 0.
- R6: The step from C4 to C5 happens only at an edge where `l2_ways` is already 0. C6 follows C5 at the next edge. A request for C5 or C6 holds the core in C4 until then.
- R7: When `wake` is sampled high while `cur_state` is not 0 and no wake is in progress, `waking` rises. `ready` rises exactly LAT(depth) edges later, with `cur_state` returning to 0 at that same edge. Until then `cur_state` and the controls hold. `shrink_en` drops in the very cycle that `wake` is high.
- R8: `ready` is high for exactly one cycle. `l2_ways` returns to `L2_WAYS` at the same edge.
- R9: A wake beats a request made in the same cycle, and the request is dropped. Requests made while a wake is in progress, or in the `ready` cycle, are ignored. A wake in C0 has no effect.
- R10: `ctx_lost` pulses together with `ready` exactly when the wake started in C6.
- R11: `pkg_state` equals the minimum of `cur_state` and every 3-bit field of `peer_states`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Sleep request strobe |
| req_state | input | 3 | Requested target depth |
| wake | input | 1 | Wake event |
| multi_proc | input | 1 | 1 when more than one processor shares memory |
| peer_states | input | 3*NUM_PEERS | Depths of the other cores, 3 bits each |
| cur_state | output | 3 | Present depth of this core |
| halt | output | 1 | Instruction pipeline stopped |
| clk_gate | output | 1 | Core clock and I/O buffers gated |
| pll_gate | output | 1 | Bus clock and PLL gated |
| snoop_off | output | 1 | Snoops not serviced |
| mem_block | output | 1 | Memory transactions blocked (single processor) |
| cache_inval | output | 1 | Cache contents marked invalid (multi-processor) |
| vsel | output | 2 | Voltage level: 0 nominal, 1 reduced, 2 lowest |
| shrink_en | output | 1 | L2 shrink running |
| l2_ways | output | $clog2(L2_WAYS+1) | Remaining L2 ways |
| waking | output | 1 | Wake latency countdown running |
| ready | output | 1 | One-cycle pulse: core back in C0 |
| ctx_lost | output | 1 | Core context lost, pulses with ready |
| pkg_state | output | 3 | Resolved package depth |

## Verification
The depth, control outputs, `waking`, `l2_ways` and `ready` are registered. Each is therefore due one edge after the stimulus that causes it. The exceptions are:
- the depth is due N edges after an accepted request for depth N;
- `ready` is due LAT(depth) edges after the edge that samples `wake`;
- the first shrink step is due `SHRINK_DIV` edges after entering C4.

`shrink_en` and `pkg_state` are combinational, so they are checked before the next edge. The bench drives inputs and samples outputs one nanosecond after a rising edge, counting edges explicitly. It also checks `ready` low one edge before it is due and low again one edge after.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;
   typedef enum logic [2:0] {
      CS_C0 = 3'd0, CS_C1 = 3'd1, CS_C2 = 3'd2, CS_C3 = 3'd3,
      CS_C4 = 3'd4, CS_C5 = 3'd5, CS_C6 = 3'd6
   } cstate_e;

   typedef struct packed {
      logic       halt;
      logic       clk_gate;
      logic       pll_gate;
      logic       snoop_off;
      logic       mem_block;
      logic       cache_inval;
      logic [1:0] vsel;
   } ctrl_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Each depth adds its actions on top of the shallower ones.
   function automatic ctrl_t depth_ctrl(input cstate_e s, input logic multi);
      ctrl_t c;
      c.halt        = (s >= CS_C1);
      c.clk_gate    = (s >= CS_C2);
      c.pll_gate    = (s >= CS_C3);
      c.snoop_off   = (s >= CS_C3);
      c.mem_block   = (s >= CS_C3) && !multi;
      c.cache_inval = (s >= CS_C3) && multi;
      if (s == CS_C6)      c.vsel = 2'd2;
      else if (s >= CS_C4) c.vsel = 2'd1;
      else                 c.vsel = 2'd0;
      return c;
   endfunction
endpackage

// File: rtl/idle_wake_timer.sv
module idle_wake_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= load - CNT_W'(1);
      end else if (busy) begin
         if (cnt_q == '0) busy  <= 1'b0;
         else             cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign done = busy && (cnt_q == '0);

   // R7
   timer_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   // R7
   timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt_q != '0) |=> busy);
endmodule

// File: rtl/idle_l2_shrink.sv
module idle_l2_shrink #(
   parameter int WAYS = 16,
   parameter int DIV  = 100
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      restore,
   output logic [$clog2(WAYS+1)-1:0] ways,
   output logic                      zero
);
   localparam int WAY_W = $clog2(WAYS + 1);
   localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

   logic tick;

   generate
      if (DIV == 1) begin : g_every
         assign tick = en;
      end else begin : g_prescale
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n || !en)              pre_q <= '0;
            else if (pre_q == PRE_W'(DIV-1)) pre_q <= '0;
            else                            pre_q <= pre_q + PRE_W'(1);
         end
         assign tick = en && (pre_q == PRE_W'(DIV-1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restore)          ways <= WAY_W'(WAYS);
      else if (tick && ways != '0)    ways <= ways - WAY_W'(1);
   end

   assign zero = (ways == '0);

   // R5
   shrink_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !restore) |=> (ways == $past(ways) || ways == $past(ways) - WAY_W'(1)));
   // R5
   shrink_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !restore) |=> $stable(ways));
endmodule

// File: rtl/idle_pkg_resolver.sv
module idle_pkg_resolver #(
   parameter int NUM_PEERS = 3
) (
   input  logic [2:0]             own,
   input  logic [3*NUM_PEERS-1:0] peers,
   output logic [2:0]             pkg
);
   logic [2:0] run_min [NUM_PEERS+1];

   assign run_min[0] = own;

   generate
      for (genvar i = 0; i < NUM_PEERS; i++) begin : g_min
         logic [2:0] p;
         assign p            = peers[3*i +: 3];
         assign run_min[i+1] = (p < run_min[i]) ? p : run_min[i];
      end
   endgenerate

   assign pkg = run_min[NUM_PEERS];
endmodule

// File: rtl/idle_pwr_seq.sv
module idle_pwr_seq
   import idle_seq_pkg::*;
#(
   parameter int NUM_PEERS  = 3,
   parameter int L2_WAYS    = 16,
   parameter int SHRINK_DIV = 100,
   parameter int LAT_C1     = 1,
   parameter int LAT_C2     = 10,
   parameter int LAT_C3     = 5000,
   parameter int LAT_C4     = 16000,
   parameter int LAT_C5     = 20000,
   parameter int LAT_C6     = 25000
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [2:0]                   req_state,
   input  logic                         wake,
   input  logic                         multi_proc,
   input  logic [3*NUM_PEERS-1:0]       peer_states,
   output logic [2:0]                   cur_state,
   output logic                         halt,
   output logic                         clk_gate,
   output logic                         pll_gate,
   output logic                         snoop_off,
   output logic                         mem_block,
   output logic                         cache_inval,
   output logic [1:0]                   vsel,
   output logic                         shrink_en,
   output logic [$clog2(L2_WAYS+1)-1:0] l2_ways,
   output logic                         waking,
   output logic                         ready,
   output logic                         ctx_lost,
   output logic [2:0]                   pkg_state
);
   localparam int LAT_MAX = imax(imax(imax(LAT_C1, LAT_C2), imax(LAT_C3, LAT_C4)),
                                 imax(LAT_C5, LAT_C6));
   localparam int CNT_W   = $clog2(LAT_MAX + 1);

   generate
      if (NUM_PEERS < 1 || L2_WAYS < 1 || SHRINK_DIV < 1) begin : g_bad_geom
         $error("idle_pwr_seq: NUM_PEERS, L2_WAYS and SHRINK_DIV must be at least 1");
      end
      if (LAT_C1 < 1 || LAT_C2 < 1 || LAT_C3 < 1 ||
          LAT_C4 < 1 || LAT_C5 < 1 || LAT_C6 < 1) begin : g_bad_lat
         $error("idle_pwr_seq: every wake latency must be at least one cycle");
      end
   endgenerate

   cstate_e          cur_q, tgt_q;
   logic             ready_q, ctx_q, from6_q;
   logic             busy, done, l2_zero;
   logic             accept, wake_go;
   logic [CNT_W-1:0] lat_sel;
   ctrl_t            ctrl;

   assign accept  = req_valid && !wake && (cur_q == CS_C0) && !busy && !ready_q &&
                    (req_state >= 3'd1) && (req_state <= 3'd6);
   assign wake_go = wake && (cur_q != CS_C0) && !busy;

   always_comb begin
      unique case (cur_q)
         CS_C2:   lat_sel = CNT_W'(LAT_C2);
         CS_C3:   lat_sel = CNT_W'(LAT_C3);
         CS_C4:   lat_sel = CNT_W'(LAT_C4);
         CS_C5:   lat_sel = CNT_W'(LAT_C5);
         CS_C6:   lat_sel = CNT_W'(LAT_C6);
         default: lat_sel = CNT_W'(LAT_C1);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q   <= CS_C0;
         tgt_q   <= CS_C0;
         ready_q <= 1'b0;
         ctx_q   <= 1'b0;
         from6_q <= 1'b0;
      end else begin
         ready_q <= 1'b0;
         ctx_q   <= 1'b0;
         if (done) begin
            cur_q   <= CS_C0;
            tgt_q   <= CS_C0;
            ready_q <= 1'b1;
            ctx_q   <= from6_q;
         end else if (wake_go) begin
            from6_q <= (cur_q == CS_C6);
         end else if (!busy) begin
            if (accept) begin
               cur_q <= CS_C1;
               tgt_q <= cstate_e'(req_state);
            end else if (cur_q != CS_C0 && cur_q < tgt_q) begin
               if (cur_q == CS_C4) begin
                  if (l2_zero) cur_q <= CS_C5;
               end else begin
                  cur_q <= cstate_e'(cur_q + 3'd1);
               end
            end
         end
      end
   end

   idle_wake_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wake_go),
      .load  (lat_sel),
      .busy  (busy),
      .done  (done)
   );

   assign shrink_en = (cur_q == CS_C4) && !busy && !wake;

   idle_l2_shrink #(.WAYS(L2_WAYS), .DIV(SHRINK_DIV)) u_shrink (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (shrink_en),
      .restore (done),
      .ways    (l2_ways),
      .zero    (l2_zero)
   );

   idle_pkg_resolver #(.NUM_PEERS(NUM_PEERS)) u_resolve (
      .own   (cur_q),
      .peers (peer_states),
      .pkg   (pkg_state)
   );

   assign ctrl        = depth_ctrl(cur_q, multi_proc);
   assign halt        = ctrl.halt;
   assign clk_gate    = ctrl.clk_gate;
   assign pll_gate    = ctrl.pll_gate;
   assign snoop_off   = ctrl.snoop_off;
   assign mem_block   = ctrl.mem_block;
   assign cache_inval = ctrl.cache_inval;
   assign vsel        = ctrl.vsel;
   assign cur_state   = cur_q;
   assign waking      = busy;
   assign ready       = ready_q;
   assign ctx_lost    = ctx_q;

   // R8
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);
   // R9
   wake_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && req_valid && cur_state == 3'd0 && !waking) |=> (cur_state == 3'd0));
   // R6
   c5_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_state == 3'd4 && l2_ways != '0) |=> (cur_state != 3'd5));
   // R11
   pkg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkg_state <= cur_state);
   // R10
   ctx_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_lost |-> ready);
   // R7
   ready_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(waking));
endmodule

// File: tb/sim_idle_pwr_seq.sv
`timescale 1ns/1ps
module sim_idle_pwr_seq;
   localparam int NP = 2, WAYS = 4, DIV = 3;
   localparam int L1 = 1, L2 = 2, L3 = 4, L4 = 5, L5 = 9, L6 = 11;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, wake = 1'b0, multi_proc = 1'b0;
   logic [2:0] req_state = 3'd0;
   logic [3*NP-1:0] peer_states = {3'd6, 3'd6};
   logic [2:0] cur_state, pkg_state;
   logic halt, clk_gate, pll_gate, snoop_off, mem_block, cache_inval;
   logic [1:0] vsel;
   logic shrink_en, waking, ready, ctx_lost;
   logic [2:0] l2_ways;

   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   idle_pwr_seq #(.NUM_PEERS(NP), .L2_WAYS(WAYS), .SHRINK_DIV(DIV),
      .LAT_C1(L1), .LAT_C2(L2), .LAT_C3(L3), .LAT_C4(L4), .LAT_C5(L5), .LAT_C6(L6)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_state(req_state),
      .wake(wake), .multi_proc(multi_proc), .peer_states(peer_states),
      .cur_state(cur_state), .halt(halt), .clk_gate(clk_gate), .pll_gate(pll_gate),
      .snoop_off(snoop_off), .mem_block(mem_block), .cache_inval(cache_inval),
      .vsel(vsel), .shrink_en(shrink_en), .l2_ways(l2_ways), .waking(waking),
      .ready(ready), .ctx_lost(ctx_lost), .pkg_state(pkg_state));

   typedef struct packed {
      logic [2:0] tgt;
      logic       multi;
      logic [7:0] ctrl;
      logic [7:0] lat;
   } vec_t;

   // ctrl = {halt, clk_gate, pll_gate, snoop_off, mem_block, cache_inval, vsel}
   localparam vec_t VECS [6] = '{
      '{3'd1, 1'b0, 8'b1000_0000, 8'(L1)},
      '{3'd2, 1'b0, 8'b1100_0000, 8'(L2)},
      '{3'd3, 1'b0, 8'b1111_1000, 8'(L3)},
      '{3'd3, 1'b1, 8'b1111_0100, 8'(L3)},
      '{3'd4, 1'b0, 8'b1111_1001, 8'(L4)},
      '{3'd4, 1'b1, 8'b1111_0101, 8'(L4)}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Wake from the present depth, expect ready after lat edges.
   task automatic wake_and_check(input int lat, input int depth, input bit ctx_exp, input string tag);
      wake = 1'b1;
      step();
      wake = 1'b0;
      chk(waking == 1'b1, {tag, " waking"}, int'(waking), 1);
      for (int n = 1; n < lat; n++) step();
      chk(ready == 1'b0 && cur_state == 3'(depth), {tag, " hold before ready"},
          int'(cur_state), depth);
      step();
      chk(ready == 1'b1 && cur_state == 3'd0, {tag, " ready at latency"}, int'(ready), 1);
      chk(l2_ways == 3'(WAYS), "R8 ways restored", int'(l2_ways), WAYS);
      chk(ctx_lost == ctx_exp, "R10 ctx_lost", int'(ctx_lost), int'(ctx_exp));
      step();
      chk(ready == 1'b0, "R8 ready one cycle", int'(ready), 0);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            report();
         end
      end
   end

   initial begin
      step();
      step();
      rst_n = 1'b1;
      // R1 reset state
      chk(cur_state == 3'd0 && {halt, clk_gate, pll_gate, snoop_off, mem_block, cache_inval} == 6'd0,
          "R1 depth/controls", int'(cur_state), 0);
      chk(vsel == 2'd0 && l2_ways == 3'(WAYS) && !ready && !ctx_lost && !waking,
          "R1 vsel/ways/flags", int'(l2_ways), WAYS);

      // Vector walk: R2 R3 R4 R7 R8 R11
      foreach (VECS[i]) begin
         multi_proc = VECS[i].multi;
         req_state  = VECS[i].tgt;
         req_valid  = 1'b1;
         step();
         req_valid = 1'b0;
         chk(cur_state == 3'd1, "R2 first step", int'(cur_state), 1);
         for (int k = 1; k < int'(VECS[i].tgt); k++) step();
         chk(cur_state == VECS[i].tgt, "R2 target reached", int'(cur_state), int'(VECS[i].tgt));
         chk({halt, clk_gate, pll_gate, snoop_off, mem_block, cache_inval, vsel} == VECS[i].ctrl,
             "R3 R4 controls", int'({halt, clk_gate, pll_gate, snoop_off, mem_block, cache_inval, vsel}),
             int'(VECS[i].ctrl));
         chk(pkg_state == VECS[i].tgt, "R11 pkg follows own", int'(pkg_state), int'(VECS[i].tgt));
         wake_and_check(int'(VECS[i].lat), int'(VECS[i].tgt), 1'b0, "R7 vector");
      end
      multi_proc = 1'b0;

      // R5 R6: request C5, shrink then step
      req_state = 3'd5;
      req_valid = 1'b1;
      step();
      req_valid = 1'b0;
      for (int k = 1; k < 4; k++) step();
      chk(cur_state == 3'd4 && shrink_en, "R5 in C4 shrinking", int'(cur_state), 4);
      for (int k = 0; k < DIV - 1; k++) step();
      chk(l2_ways == 3'(WAYS), "R5 no step early", int'(l2_ways), WAYS);
      step();
      chk(l2_ways == 3'(WAYS - 1), "R5 first step", int'(l2_ways), WAYS - 1);
      for (int k = 0; k < DIV * (WAYS - 1); k++) step();
      chk(l2_ways == 3'd0 && cur_state == 3'd4, "R6 held in C4 at zero", int'(cur_state), 4);
      step();
      chk(cur_state == 3'd5 && vsel == 2'd1 && !shrink_en, "R6 enter C5", int'(cur_state), 5);
      // R11 package resolution
      peer_states = {3'd4, 3'd3};
      #1;
      chk(pkg_state == 3'd3, "R11 min of peers", int'(pkg_state), 3);
      peer_states = {3'd6, 3'd6};
      #1;
      chk(pkg_state == 3'd5, "R11 own shallowest", int'(pkg_state), 5);
      wake_and_check(L5, 5, 1'b0, "R7 from C5");

      // R6 R10: C6 path and context lost
      req_state = 3'd6;
      req_valid = 1'b1;
      step();
      req_valid = 1'b0;
      for (int k = 1; k < 4 + DIV * WAYS + 2; k++) step();
      chk(cur_state == 3'd6 && vsel == 2'd2, "R6 R3 C6 reached", int'(cur_state), 6);
      wake_and_check(L6, 6, 1'b1, "R10 from C6");

      // R7: shrink stops in the wake cycle
      req_state = 3'd4;
      req_valid = 1'b1;
      step();
      req_valid = 1'b0;
      for (int k = 1; k < 4; k++) step();
      wake = 1'b1;
      #1;
      chk(shrink_en == 1'b0, "R7 shrink stops on wake", int'(shrink_en), 0);
      wake = 1'b0;
      #1;
      wake_and_check(L4, 4, 1'b0, "R7 C4 again");

      // R9: wake and request together in C0
      req_state = 3'd3;
      req_valid = 1'b1;
      wake = 1'b1;
      step();
      chk(cur_state == 3'd0 && !waking, "R9 wake beats request", int'(cur_state), 0);
      // R9: wake alone in C0 has no effect
      req_valid = 1'b0;
      step();
      wake = 1'b0;
      chk(!waking && !ready && cur_state == 3'd0, "R9 wake in C0 ignored", int'(waking), 0);

      // R9: wake while stepping; requests blocked through ready cycle
      req_state = 3'd3;
      req_valid = 1'b1;
      step();
      req_valid = 1'b0;
      wake = 1'b1;
      step();
      wake = 1'b0;
      req_state = 3'd2;
      req_valid = 1'b1;
      chk(waking && cur_state == 3'd1, "R7 wake mid-entry holds", int'(cur_state), 1);
      step();
      chk(ready && cur_state == 3'd0, "R7 ready from C1", int'(ready), 1);
      step();
      chk(cur_state == 3'd0, "R9 request ignored in ready cycle", int'(cur_state), 0);
      step();
      chk(cur_state == 3'd1, "R2 request accepted after ready", int'(cur_state), 1);
      req_valid = 1'b0;
      step();
      wake_and_check(L2, 2, 1'b0, "R7 from C2");

      // R2: invalid targets ignored
      req_state = 3'd7;
      req_valid = 1'b1;
      step();
      chk(cur_state == 3'd0, "R2 target 7 ignored", int'(cur_state), 0);
      req_state = 3'd0;
      step();
      req_valid = 1'b0;
      chk(cur_state == 3'd0 && !halt, "R2 target 0 ignored", int'(cur_state), 0);

      report();
   end
endmodule